// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. It reads descriptors from a two-level table hierarchy in memory. A requester presents the linear address together with a privilege bit (user or kernel). The walker also reads a 20-bit directory base input, which locates the first-level table. It then fetches one descriptor per level through a single-outstanding word-read port. Each descriptor's upper 20 bits give a 4 KB-aligned base. Its low bits carry a present flag, a user-access flag and a page-size flag.

A normal walk takes two reads and ends in a 4 KB frame. When the large-page enable input is high and a directory entry has its page-size flag set, the walk stops at the directory and maps a 4 MB region. A walk reports its outcome with a single completion pulse. The pulse carries either the physical address or a fault with a 2-bit cause. The walk stops early when a descriptor is absent, or when a user request meets a kernel-only descriptor.

Top module: `ptw_walker`

## Requirements
- R1: The first read of a walk targets `{dirBase, 12'h000} + 4 * linAddr[31:22]`.
- R2: The second read targets `{pde[31:12], 12'h000} + 4 * linAddr[21:12]`. Here pde is the directory entry returned by the first read.
- R3: A successful 4 KB walk returns `{pte[31:12], linAddr[11:0]}` with doneFault = 0 and doneCause = 0. Here pte is the table entry.
- R4: A directory entry with bit 0 (present) clear ends the walk after one read. It reports doneFault = 1 and doneCause = 1, and its base field is not used.
- R5: A table entry with bit 0 clear reports doneFault = 1 and doneCause = 2.
- R6: A user request (reqUser = 1) that meets a descriptor with bit 2 (user access) clear at either level faults with doneCause = 3. Kernel requests ignore bit 2. The present check takes priority over the privilege check.
- R7: With bigPageEn = 1 and bit 7 (page size) set in a present, accessible directory entry, the walk uses one read. It returns `{pde[31:22], linAddr[21:0]}`.
- R8: With bigPageEn = 0, bit 7 of the directory entry has no effect and a full two-level walk takes place.
- R9: A request is taken only when reqReady is high, and reqReady is low for the whole walk. Each accepted request gives exactly one single-cycle doneValid pulse.
- R10: At most one read is outstanding. memReqValid and memReqAddr stay unchanged until memRspValid arrives.
- R11: During and after reset, reqReady = 1, memReqValid = 0 and doneValid = 0. This holds even when reset is applied in the middle of a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request will be taken |
| reqLinAddr | input | 32 | Linear address to translate |
| reqUser | input | 1 | 1 = user privilege, 0 = kernel |
| dirBase | input | 20 | Directory base, in 4 KB units |
| bigPageEn | input | 1 | Allows 4 MB mappings via directory bit 7 |
| memReqValid | output | 1 | Read request held until the response |
| memReqAddr | output | 32 | Byte address of descriptor to read |
| memRspValid | input | 1 | Read data valid this cycle |
| memRspData | input | 32 | Descriptor word |
| doneValid | output | 1 | One-cycle completion pulse |
| donePhysAddr | output | 32 | Translated address (0 on fault) |
| doneFault | output | 1 | Walk ended in a fault |
| doneCause | output | 2 | 0 none, 1 directory absent, 2 table absent, 3 privilege |

## Verification
The assertions check the following on every cycle:
- the directory read address formed from the accepted request;
- the read port holding steady until the response arrives;
- mutual exclusion of the busy, ready and done conditions;
- single-cycle done pulses;
- the agreement of the fault flag with the cause;
- the page offset carried into every successful result.

Only the bench's scenarios can show the following:
- which descriptor words lead to which cause;
- the table-level address;
- the number of reads in large-page and early-fault walks;
- the effect of the page-size flag when large pages are disabled;
- recovery from a reset applied in the middle of a walk.

These depend on descriptor contents that the bench supplies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE       = 2'd0,
    CAUSE_DIR_ABSENT = 2'd1,
    CAUSE_TAB_ABSENT = 2'd2,
    CAUSE_PRIV       = 2'd3
  } fault_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIR_WAIT,
    ST_TAB_WAIT,
    ST_REPORT
  } walk_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic         capture;
    logic         savePde;
    logic         useTable;
    logic         finishSmall;
    logic         finishBig;
    logic         finishFault;
    fault_cause_e cause;
  } walk_ctrl_t;

  // descriptor decode returned to control
  typedef struct packed {
    logic present;
    logic userOk;
    logic bigPage;
  } walk_status_t;

endpackage

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int ADDR_W           = 32,
  parameter int OFF_W            = 12,
  parameter int IDX_W            = 10,
  parameter int PRES_BIT         = 0,
  parameter int US_BIT           = 2,
  parameter int PS_BIT           = 7,
  parameter bit BIG_PAGE_SUPPORT = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  walk_ctrl_t                ctrl,
  input  logic [ADDR_W-1:0]         reqLinAddr,
  input  logic                      reqUser,
  input  logic [ADDR_W-OFF_W-1:0]   dirBase,
  input  logic                      bigPageEn,
  input  logic [ADDR_W-1:0]         memRspData,
  output walk_status_t              status,
  output logic [ADDR_W-1:0]         memReqAddr,
  output logic [ADDR_W-1:0]         physAddr,
  output logic                      fault,
  output fault_cause_e              cause
);

  localparam int BASE_W  = ADDR_W - OFF_W;
  localparam int TAB_LSB = OFF_W;
  localparam int DIR_LSB = OFF_W + IDX_W;
  localparam int DIR_W   = ADDR_W - DIR_LSB;
  localparam int ENT_SH  = 2;

  logic [ADDR_W-1:0] linQ;
  logic              userQ;
  logic              bigEnQ;
  logic [BASE_W-1:0] dirBaseQ;
  logic [BASE_W-1:0] tabBaseQ;
  logic [ADDR_W-1:0] physQ;
  logic              faultQ;
  fault_cause_e      causeQ;

  logic [DIR_W-1:0]   dirIdx;
  logic [IDX_W-1:0]   tabIdx;
  logic [ADDR_W-1:0]  dirEntryAddr;
  logic [ADDR_W-1:0]  tabEntryAddr;
  logic [ADDR_W-1:0]  smallPhys;
  logic [ADDR_W-1:0]  bigPhys;
  logic               unusedRspBits;

  assign dirIdx = linQ[ADDR_W-1:DIR_LSB];
  assign tabIdx = linQ[DIR_LSB-1:TAB_LSB];

  assign dirEntryAddr = {dirBaseQ, {OFF_W{1'b0}}}
                      + ADDR_W'({dirIdx, {ENT_SH{1'b0}}});
  assign tabEntryAddr = {tabBaseQ, {OFF_W{1'b0}}}
                      + ADDR_W'({tabIdx, {ENT_SH{1'b0}}});

  assign memReqAddr = ctrl.useTable ? tabEntryAddr : dirEntryAddr;

  assign smallPhys = {memRspData[ADDR_W-1:OFF_W], linQ[OFF_W-1:0]};
  assign bigPhys   = {memRspData[ADDR_W-1:DIR_LSB], linQ[DIR_LSB-1:0]};

  assign status.present = memRspData[PRES_BIT];
  assign status.userOk  = !userQ || memRspData[US_BIT];

  generate
    if (BIG_PAGE_SUPPORT) begin : g_big
      assign status.bigPage = bigEnQ && memRspData[PS_BIT];
    end else begin : g_nobig
      assign status.bigPage = 1'b0;
    end
  endgenerate

  assign unusedRspBits = ^{memRspData, bigEnQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linQ     <= '0;
      userQ    <= 1'b0;
      bigEnQ   <= 1'b0;
      dirBaseQ <= '0;
      tabBaseQ <= '0;
      physQ    <= '0;
      faultQ   <= 1'b0;
      causeQ   <= CAUSE_NONE;
    end else begin
      if (ctrl.capture) begin
        linQ     <= reqLinAddr;
        userQ    <= reqUser;
        bigEnQ   <= bigPageEn;
        dirBaseQ <= dirBase;
      end
      if (ctrl.savePde) begin
        tabBaseQ <= memRspData[ADDR_W-1:OFF_W];
      end
      if (ctrl.finishSmall) begin
        physQ  <= smallPhys;
        faultQ <= 1'b0;
        causeQ <= CAUSE_NONE;
      end else if (ctrl.finishBig) begin
        physQ  <= bigPhys;
        faultQ <= 1'b0;
        causeQ <= CAUSE_NONE;
      end else if (ctrl.finishFault) begin
        physQ  <= '0;
        faultQ <= 1'b1;
        causeQ <= ctrl.cause;
      end
    end
  end

  assign physAddr = physQ;
  assign fault    = faultQ;
  assign cause    = causeQ;

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRspValid,
  input  walk_status_t status,
  output walk_ctrl_t   ctrl,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         doneValid
);

  walk_state_e stateQ, stateD;

  always_comb begin
    ctrl        = '0;
    stateD      = stateQ;
    reqReady    = (stateQ == ST_IDLE);
    memReqValid = (stateQ == ST_DIR_WAIT) || (stateQ == ST_TAB_WAIT);
    doneValid   = (stateQ == ST_REPORT);
    ctrl.useTable = (stateQ == ST_TAB_WAIT);
    ctrl.cause    = CAUSE_NONE;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.capture = 1'b1;
          stateD       = ST_DIR_WAIT;
        end
      end
      ST_DIR_WAIT: begin
        if (memRspValid) begin
          if (!status.present) begin
            ctrl.finishFault = 1'b1;
            ctrl.cause       = CAUSE_DIR_ABSENT;
            stateD           = ST_REPORT;
          end else if (!status.userOk) begin
            ctrl.finishFault = 1'b1;
            ctrl.cause       = CAUSE_PRIV;
            stateD           = ST_REPORT;
          end else if (status.bigPage) begin
            ctrl.finishBig = 1'b1;
            stateD         = ST_REPORT;
          end else begin
            ctrl.savePde = 1'b1;
            stateD       = ST_TAB_WAIT;
          end
        end
      end
      ST_TAB_WAIT: begin
        if (memRspValid) begin
          stateD = ST_REPORT;
          if (!status.present) begin
            ctrl.finishFault = 1'b1;
            ctrl.cause       = CAUSE_TAB_ABSENT;
          end else if (!status.userOk) begin
            ctrl.finishFault = 1'b1;
            ctrl.cause       = CAUSE_PRIV;
          end else begin
            ctrl.finishSmall = 1'b1;
          end
        end
      end
      ST_REPORT: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int ADDR_W           = 32,
  parameter int OFF_W            = 12,
  parameter int IDX_W            = 10,
  parameter bit BIG_PAGE_SUPPORT = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqLinAddr,
  input  logic                    reqUser,
  input  logic [ADDR_W-OFF_W-1:0] dirBase,
  input  logic                    bigPageEn,
  output logic                    memReqValid,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memRspValid,
  input  logic [ADDR_W-1:0]       memRspData,
  output logic                    doneValid,
  output logic [ADDR_W-1:0]       donePhysAddr,
  output logic                    doneFault,
  output logic [1:0]              doneCause
);

  walk_ctrl_t   ctrl;
  walk_status_t status;
  fault_cause_e causeInt;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .status      (status),
    .ctrl        (ctrl),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .doneValid   (doneValid)
  );

  ptw_datapath #(
    .ADDR_W           (ADDR_W),
    .OFF_W            (OFF_W),
    .IDX_W            (IDX_W),
    .BIG_PAGE_SUPPORT (BIG_PAGE_SUPPORT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .reqLinAddr (reqLinAddr),
    .reqUser    (reqUser),
    .dirBase    (dirBase),
    .bigPageEn  (bigPageEn),
    .memRspData (memRspData),
    .status     (status),
    .memReqAddr (memReqAddr),
    .physAddr   (donePhysAddr),
    .fault      (doneFault),
    .cause      (causeInt)
  );

  assign doneCause = causeInt;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqLinAddr,
  input logic [19:0] dirBase,
  input logic        memReqValid,
  input logic [31:0] memReqAddr,
  input logic        memRspValid,
  input logic        doneValid,
  input logic [31:0] donePhysAddr,
  input logic        doneFault,
  input logic [1:0]  doneCause
);

  logic [11:0] takenOffset;

  always_ff @(posedge clk) begin
    if (!rstN)                      takenOffset <= '0;
    else if (reqValid && reqReady)  takenOffset <= reqLinAddr[11:0];
  end

  // R1: first read address follows the accepted request
  a_r1_dir_addr: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> memReqValid &&
      memReqAddr == ({$past(dirBase), 12'h000} + {20'h0, $past(reqLinAddr[31:22]), 2'b00}));

  // R10: read held steady until answered
  a_r10_hold_read: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> memReqValid && $stable(memReqAddr));

  // R9: busy excludes ready and done
  a_r9_busy_excl: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady && !doneValid);

  // R9: completion lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R4: fault flag and cause agree
  a_r4_cause_flag: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneFault == (doneCause != 2'd0)));

  // R3: page offset preserved on success
  a_r3_offset: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !doneFault |-> donePhysAddr[11:0] == takenOffset);

  // R11: idle right after reset
  a_r11_reset_idle: assert property (@(posedge clk)
    $rose(rstN) |-> reqReady && !memReqValid && !doneValid);

endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqLinAddr   (reqLinAddr),
  .dirBase      (dirBase),
  .memReqValid  (memReqValid),
  .memReqAddr   (memReqAddr),
  .memRspValid  (memRspValid),
  .doneValid    (doneValid),
  .donePhysAddr (donePhysAddr),
  .doneFault    (doneFault),
  .doneCause    (doneCause)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;

  typedef struct packed {
    logic [31:0] lin;
    logic        user;
    logic        bigEn;
    logic [31:0] pde;
    logic [31:0] pte;
    logic [31:0] expPhys;
    logic        expFault;
    logic [1:0]  expCause;
    logic [1:0]  expReads;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{32'h06C23150, 1'b0, 1'b0, 32'h05E37001, 32'h23C69001, 32'h23C69150, 1'b0, 2'd0, 2'd2},
    '{32'h06C23150, 1'b0, 1'b0, 32'h05E37000, 32'h23C69001, 32'h00000000, 1'b1, 2'd1, 2'd1},
    '{32'h06C23150, 1'b0, 1'b0, 32'h05E37001, 32'h23C69000, 32'h00000000, 1'b1, 2'd2, 2'd2},
    '{32'h06C23150, 1'b1, 1'b0, 32'h05E37005, 32'h23C69001, 32'h00000000, 1'b1, 2'd3, 2'd2},
    '{32'h06C23150, 1'b1, 1'b0, 32'h05E37001, 32'h23C69005, 32'h00000000, 1'b1, 2'd3, 2'd1},
    '{32'h06C23150, 1'b1, 1'b0, 32'h05E37005, 32'h23C69005, 32'h23C69150, 1'b0, 2'd0, 2'd2},
    '{32'h06C23150, 1'b0, 1'b1, 32'h12C00081, 32'h23C69001, 32'h12C23150, 1'b0, 2'd0, 2'd1},
    '{32'h06C23150, 1'b0, 1'b0, 32'h12C00081, 32'h23C69001, 32'h23C69150, 1'b0, 2'd0, 2'd2},
    '{32'hFFFFFFFF, 1'b0, 1'b0, 32'hABCDE001, 32'h00001003, 32'h00001FFF, 1'b0, 2'd0, 2'd2},
    '{32'h00000000, 1'b0, 1'b0, 32'h00000001, 32'hFFFFF001, 32'hFFFFF000, 1'b0, 2'd0, 2'd2},
    '{32'h06C23150, 1'b1, 1'b1, 32'h12C00081, 32'h23C69005, 32'h00000000, 1'b1, 2'd3, 2'd1},
    '{32'h06C23150, 1'b0, 1'b1, 32'h12C00080, 32'h23C69001, 32'h00000000, 1'b1, 2'd1, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqLinAddr = '0;
  logic        reqUser = 1'b0;
  logic [19:0] dirBase = 20'h05C71;
  logic        bigPageEn = 1'b0;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        doneValid;
  logic [31:0] donePhysAddr;
  logic        doneFault;
  logic [1:0]  doneCause;

  int checks = 0;
  int fails  = 0;

  // memory model state
  logic [31:0] pdeAddr, pteAddr, pdeWord, pteWord;
  int          rspDelay = 0;
  int          waitCnt  = 0;
  int          readCount = 0;
  logic [31:0] readAddr [2];

  always #4 clk = ~clk;

  ptw_walker dut (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .reqLinAddr   (reqLinAddr),
    .reqUser      (reqUser),
    .dirBase      (dirBase),
    .bigPageEn    (bigPageEn),
    .memReqValid  (memReqValid),
    .memReqAddr   (memReqAddr),
    .memRspValid  (memRspValid),
    .memRspData   (memRspData),
    .doneValid    (doneValid),
    .donePhysAddr (donePhysAddr),
    .doneFault    (doneFault),
    .doneCause    (doneCause)
  );

  // responder: answers on falling edges after rspDelay waiting cycles
  initial begin
    forever begin
      @(negedge clk);
      if (!rstN) begin
        memRspValid = 1'b0;
        waitCnt = 0;
      end else if (memRspValid) begin
        memRspValid = 1'b0;
        waitCnt = 0;
      end else if (memReqValid) begin
        if (waitCnt >= rspDelay) begin
          if (memReqAddr == pdeAddr)      memRspData = pdeWord;
          else if (memReqAddr == pteAddr) memRspData = pteWord;
          else                            memRspData = 32'h0;
          if (readCount < 2) readAddr[readCount] = memReqAddr;
          readCount++;
          memRspValid = 1'b1;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runWalk(input vec_t v, input int delay);
    bit seen = 1'b0;
    pdeWord   = v.pde;
    pteWord   = v.pte;
    pdeAddr   = {dirBase, 12'h000} + {20'h0, v.lin[31:22], 2'b00};
    pteAddr   = {v.pde[31:12], 12'h000} + {20'h0, v.lin[21:12], 2'b00};
    readCount = 0;
    readAddr[0] = '0;
    readAddr[1] = '0;
    rspDelay  = delay;
    @(negedge clk);
    check(reqReady == 1'b1, "R9 ready before request", {31'h0, reqReady}, 32'h1);
    reqLinAddr = v.lin;
    reqUser    = v.user;
    bigPageEn  = v.bigEn;
    reqValid   = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R9 busy after accept", {31'h0, reqReady}, 32'h0);
    for (int i = 0; i < 60; i++) begin
      if (doneValid) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
    check(seen, "R9 completion seen", {31'h0, seen}, 32'h1);
    if (seen) begin
      check(doneFault == v.expFault, "R4 R5 R6 fault flag", {31'h0, doneFault}, {31'h0, v.expFault});
      check(doneCause == v.expCause, "R4 R5 R6 cause", {30'h0, doneCause}, {30'h0, v.expCause});
      if (!v.expFault)
        check(donePhysAddr == v.expPhys, "R3 R7 R8 physical address", donePhysAddr, v.expPhys);
      check(readCount == int'(v.expReads), "R4 R7 R8 read count", readCount, {30'h0, v.expReads});
      check(readAddr[0] == pdeAddr, "R1 directory read address", readAddr[0], pdeAddr);
      if (v.expReads == 2'd2)
        check(readAddr[1] == pteAddr, "R2 table read address", readAddr[1], pteAddr);
      @(negedge clk);
      check(doneValid == 1'b0, "R9 single done pulse", {31'h0, doneValid}, 32'h0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1,    "R11 ready in reset", {31'h0, reqReady}, 32'h1);
    check(memReqValid == 1'b0, "R11 no read in reset", {31'h0, memReqValid}, 32'h0);
    check(doneValid == 1'b0,   "R11 no done in reset", {31'h0, doneValid}, 32'h0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(doneValid == 1'b0 && memReqValid == 1'b0, "R11 quiet when idle",
          {30'h0, doneValid, memReqValid}, 32'h0);

    // main vector table, varying memory latency
    for (int i = 0; i < NVEC; i++) begin
      runWalk(VECS[i], i % 4);
    end

    // back-to-back repeat with long latency (R10 hold is asserted meanwhile)
    runWalk(VECS[0], 7);
    runWalk(VECS[6], 0);

    // R11: reset in the middle of a walk
    pdeWord  = 32'h05E37001;
    pdeAddr  = 32'hFFFFFFF0;
    rspDelay = 1000;
    @(negedge clk);
    reqLinAddr = 32'h06C23150;
    reqValid   = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    check(memReqValid == 1'b1, "R10 read still outstanding", {31'h0, memReqValid}, 32'h1);
    rstN = 1'b0;
    @(negedge clk);
    check(memReqValid == 1'b0 && reqReady == 1'b1, "R11 reset aborts walk",
          {30'h0, memReqValid, reqReady}, 32'h1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(doneValid == 1'b0, "R11 no done after abort", {31'h0, doneValid}, 32'h0);
    runWalk(VECS[0], 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule